// File: doc/BRIEF.md
# Processor ALU Status Flag Register

This block is the status word of a small 16-bit processor. Each cycle it samples the result of a byte- or word-sized ALU operation together with the per-bit carry chain of that operation and a size select. From these it derives carry, half carry, negative, signed overflow and zero. A per-flag enable vector lets each instruction change only the flags it owns. A sticky zero mode supports multi-word arithmetic: once any partial result is nonzero, Z stays clear for the rest of the chain.

The same register holds a 3-bit CPU priority field and a repeat-loop-active bit. A fourth priority bit, kept elsewhere in the core, is joined above the field to form the effective 4-bit CPU priority. An external nesting-disable input locks the field against software writes. A loop controller sets and clears the repeat bit, and software cannot write it. Software reads the whole word and writes the arithmetic flags and the priority field. When hardware and software update the same flag in the same cycle, hardware wins.

Top module: `cpu_flag_reg`

## Requirements
- R1: After an active-low reset every bit of `sr_q` is 0. Bits 15 to 9 of `sr_q` always read 0, whatever is written.
- R2: The half-carry flag DC sits at bit 8. On an enabled update it takes `alu_cout[3]` for a byte operation (`alu_word`=0) and `alu_cout[7]` for a word operation.
- R3: The carry flag C sits at bit 0. On an enabled update it takes `alu_cout[7]` for a byte operation and `alu_cout[15]` for a word operation.
- R4: The negative flag N sits at bit 3. On an enabled update it takes result bit 7 (byte) or result bit 15 (word).
- R5: The overflow flag OV sits at bit 2. On an enabled update it is set when the carry into the sized MSB differs from the carry out of it, which is two's-complement signed overflow.
- R6: The zero flag Z sits at bit 1. On an enabled update with `z_sticky`=0 it is 1 exactly when the sized result (`alu_res[7:0]` for byte, all 16 bits for word) is zero. The upper byte is ignored in byte mode.
- R7: With `z_sticky`=1, an enabled Z update clears Z for a nonzero sized result and leaves Z unchanged for a zero result.
- R8: `upd_en` bit 0 enables C, bit 1 Z, bit 2 OV, bit 3 N and bit 4 DC. A flag whose enable is 0 keeps its value unless software writes it.
- R9: A software write (`sw_we`) loads DC, N, OV, Z and C from the same bit positions of `sw_wdata`. For any flag whose enable is 1 in that cycle, the hardware value wins.
- R10: The repeat-active bit sits at bit 4. `rpt_set` sets it and `rpt_clr` clears it, with clear winning if both are high. Software writes never change it.
- R11: The priority field sits at bits 7 to 5. A software write loads it from `sw_wdata[7:5]` only while `nest_dis` is 0. While `nest_dis` is 1 the field keeps its value.
- R12: `cpu_prio` equals `{ipl_hi, sr_q[7:5]}`. `user_irq_off` is 1 exactly when the 3-bit field is 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_res | input | 16 | ALU result of the current operation |
| alu_cout | input | 16 | Carry/borrow out of each result bit |
| alu_word | input | 1 | 1 = word operation, 0 = byte operation |
| upd_en | input | 5 | Per-flag hardware update enables (C, Z, OV, N, DC from bit 0) |
| z_sticky | input | 1 | Zero flag runs in sticky multi-precision mode |
| rpt_set | input | 1 | Repeat loop started |
| rpt_clr | input | 1 | Repeat loop finished |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 16 | Software write data |
| nest_dis | input | 1 | Locks the priority field against software writes |
| ipl_hi | input | 1 | Fourth (upper) CPU priority bit |
| sr_q | output | 16 | Status register read value |
| cpu_prio | output | 4 | Effective CPU priority level |
| user_irq_off | output | 1 | Priority field at 7, user interrupts masked |

## Verification
Every flag is a single register bit that is visible on `sr_q` in the cycle after the edge that loads it. A wrong tap, a wrong size decode or a lost enable therefore shows at the port one cycle after the offending operation, and it stays visible until the next update of that flag. Sticky zero and the hardware-over-software rule only show their errors over a sequence of operations, so the bench chains operations and checks the state carried between them. A corrupt priority field reaches `cpu_prio` and `user_irq_off` on the same cycle it reaches `sr_q`.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
  // status word layout
  localparam int SR_W       = 16;
  localparam int POS_C      = 0;
  localparam int POS_Z      = 1;
  localparam int POS_OV     = 2;
  localparam int POS_N      = 3;
  localparam int POS_RA     = 4;
  localparam int POS_IPL_LO = 5;
  localparam int IPL_W      = 3;
  localparam int POS_DC     = 8;

  // index of each arithmetic flag in the enable / value vectors
  localparam int NFLAG = 5;
  localparam int FI_C  = 0;
  localparam int FI_Z  = 1;
  localparam int FI_OV = 2;
  localparam int FI_N  = 3;
  localparam int FI_DC = 4;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flagreg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res,
  input  logic [DATA_W-1:0] cout,
  input  logic              word,
  output flag_vec_t         hw_val,
  output logic              res_zero
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int MSB_W  = DATA_W - 1;
  localparam int MSB_B  = BYTE_W - 1;
  localparam int HC_W   = BYTE_W - 1;
  localparam int HC_B   = NIB_W - 1;

  // pick a bit of v at the word or byte position
  function automatic logic size_tap(input logic [DATA_W-1:0] v, input logic w,
                                    input int hi, input int lo);
    return w ? v[hi] : v[lo];
  endfunction

  // signed overflow: carry into MSB differs from carry out of MSB
  function automatic logic signed_ovf(input logic [DATA_W-1:0] c, input logic w);
    return w ? (c[MSB_W] ^ c[MSB_W-1]) : (c[MSB_B] ^ c[MSB_B-1]);
  endfunction

  function automatic logic sized_zero(input logic [DATA_W-1:0] r, input logic w);
    return w ? ~|r : ~|r[BYTE_W-1:0];
  endfunction

  always_comb begin
    res_zero      = sized_zero(res, word);
    hw_val        = '0;
    hw_val[FI_C]  = size_tap(cout, word, MSB_W, MSB_B);
    hw_val[FI_DC] = size_tap(cout, word, HC_W, HC_B);
    hw_val[FI_N]  = size_tap(res, word, MSB_W, MSB_B);
    hw_val[FI_OV] = signed_ovf(cout, word);
    hw_val[FI_Z]  = res_zero;
  end
endmodule

// File: rtl/flag_bits.sv
module flag_bits
  import flagreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t upd_en,
  input  flag_vec_t hw_val,
  input  logic      z_sticky,
  input  logic      sw_we,
  input  flag_vec_t sw_val,
  output flag_vec_t flag_q,
  output flag_vec_t sw_take
);
  flag_vec_t hw_eff;

  // sticky zero: zero result keeps Z, nonzero clears it
  always_comb begin
    hw_eff       = hw_val;
    hw_eff[FI_Z] = z_sticky ? (hw_val[FI_Z] & flag_q[FI_Z]) : hw_val[FI_Z];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign sw_take[i] = sw_we & ~upd_en[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (upd_en[i])  flag_q[i] <= hw_eff[i];
      else if (sw_take[i]) flag_q[i] <= sw_val[i];
    end
  end
endmodule

// File: rtl/prio_field.sv
module prio_field
  import flagreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [IPL_W-1:0] sw_ipl,
  input  logic             nest_dis,
  input  logic             ipl_hi,
  output logic [IPL_W-1:0] ipl_q,
  output logic [IPL_W:0]   prio,
  output logic             all_masked,
  output logic             ipl_load
);
  assign ipl_load = sw_we & ~nest_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ipl_q <= '0;
    else if (ipl_load) ipl_q <= sw_ipl;
  end

  assign prio       = {ipl_hi, ipl_q};
  assign all_masked = &ipl_q;
endmodule

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg
  import flagreg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] alu_cout,
  input  logic              alu_word,
  input  logic [NFLAG-1:0]  upd_en,
  input  logic              z_sticky,
  input  logic              rpt_set,
  input  logic              rpt_clr,
  input  logic              sw_we,
  input  logic [SR_W-1:0]   sw_wdata,
  input  logic              nest_dis,
  input  logic              ipl_hi,
  output logic [SR_W-1:0]   sr_q,
  output logic [IPL_W:0]    cpu_prio,
  output logic              user_irq_off
);
  flag_vec_t        hw_val, sw_val, flag_q, sw_take;
  logic             res_zero;
  logic             hw_c;
  logic [IPL_W-1:0] ipl_q;
  logic             ipl_load;
  logic             ra_q;
  logic             unused_wbits;

  assign unused_wbits = ^{sw_wdata[SR_W-1:POS_DC+1], sw_wdata[POS_RA]};

  flag_calc #(.DATA_W(DATA_W)) u_calc (
    .res      (alu_res),
    .cout     (alu_cout),
    .word     (alu_word),
    .hw_val   (hw_val),
    .res_zero (res_zero)
  );
  assign hw_c = hw_val[FI_C];

  always_comb begin
    sw_val        = '0;
    sw_val[FI_C]  = sw_wdata[POS_C];
    sw_val[FI_Z]  = sw_wdata[POS_Z];
    sw_val[FI_OV] = sw_wdata[POS_OV];
    sw_val[FI_N]  = sw_wdata[POS_N];
    sw_val[FI_DC] = sw_wdata[POS_DC];
  end

  flag_bits u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .hw_val   (hw_val),
    .z_sticky (z_sticky),
    .sw_we    (sw_we),
    .sw_val   (sw_val),
    .flag_q   (flag_q),
    .sw_take  (sw_take)
  );

  prio_field u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_we      (sw_we),
    .sw_ipl     (sw_wdata[POS_IPL_LO +: IPL_W]),
    .nest_dis   (nest_dis),
    .ipl_hi     (ipl_hi),
    .ipl_q      (ipl_q),
    .prio       (cpu_prio),
    .all_masked (user_irq_off),
    .ipl_load   (ipl_load)
  );

  // repeat-loop-active bit: hardware only, clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ra_q <= 1'b0;
    else if (rpt_clr) ra_q <= 1'b0;
    else if (rpt_set) ra_q <= 1'b1;
  end

  always_comb begin
    sr_q                           = '0;
    sr_q[POS_C]                    = flag_q[FI_C];
    sr_q[POS_Z]                    = flag_q[FI_Z];
    sr_q[POS_OV]                   = flag_q[FI_OV];
    sr_q[POS_N]                    = flag_q[FI_N];
    sr_q[POS_RA]                   = ra_q;
    sr_q[POS_IPL_LO +: IPL_W]      = ipl_q;
    sr_q[POS_DC]                   = flag_q[FI_DC];
  end
endmodule

// File: rtl/flagreg_checker.sv
module flagreg_checker
  import flagreg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SR_W-1:0]  sr_q,
  input logic [IPL_W:0]   cpu_prio,
  input logic             user_irq_off,
  input logic             ipl_hi,
  input logic             nest_dis,
  input logic             sw_we,
  input logic [NFLAG-1:0] upd_en,
  input logic             z_sticky,
  input logic             res_zero,
  input logic             hw_c,
  input logic             rpt_set,
  input logic             rpt_clr
);
  p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[SR_W-1:POS_DC+1] == '0);

  p_carry_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en[FI_C] |=> sr_q[POS_C] == $past(hw_c));

  p_zsticky_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en[FI_Z] && z_sticky && res_zero) |=> $stable(sr_q[POS_Z]));

  p_zsticky_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en[FI_Z] && z_sticky && !res_zero) |=> !sr_q[POS_Z]);

  p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en[FI_C] && !sw_we) |=> $stable(sr_q[POS_C]));

  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en[FI_C] && sw_we) |=> sr_q[POS_C] == $past(hw_c));

  p_ra_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_clr |=> !sr_q[POS_RA]);

  p_ra_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_set && !rpt_clr) |=> sr_q[POS_RA]);

  p_ra_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt_set && !rpt_clr) |=> $stable(sr_q[POS_RA]));

  p_ipl_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_dis || !sw_we) |=> $stable(sr_q[POS_IPL_LO +: IPL_W]));

  p_prio_join_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_prio == {ipl_hi, sr_q[POS_IPL_LO +: IPL_W]}) &&
    (user_irq_off == (sr_q[POS_IPL_LO +: IPL_W] == '1)));
endmodule

bind cpu_flag_reg flagreg_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sr_q         (sr_q),
  .cpu_prio     (cpu_prio),
  .user_irq_off (user_irq_off),
  .ipl_hi       (ipl_hi),
  .nest_dis     (nest_dis),
  .sw_we        (sw_we),
  .upd_en       (upd_en),
  .z_sticky     (z_sticky),
  .res_zero     (res_zero),
  .hw_c         (hw_c),
  .rpt_set      (rpt_set),
  .rpt_clr      (rpt_clr)
);

// File: tb/cpu_flag_reg_test.sv
module cpu_flag_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] alu_res = '0, alu_cout = '0, sw_wdata = '0;
  logic        alu_word = 1'b0, z_sticky = 1'b0, rpt_set = 1'b0, rpt_clr = 1'b0;
  logic        sw_we = 1'b0, nest_dis = 1'b0, ipl_hi = 1'b0;
  logic [4:0]  upd_en = '0;
  logic [15:0] sr_q;
  logic [3:0]  cpu_prio;
  logic        user_irq_off;

  always #2.5 clk = ~clk;

  cpu_flag_reg uut (
    .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_cout(alu_cout),
    .alu_word(alu_word), .upd_en(upd_en), .z_sticky(z_sticky),
    .rpt_set(rpt_set), .rpt_clr(rpt_clr), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .nest_dis(nest_dis), .ipl_hi(ipl_hi), .sr_q(sr_q), .cpu_prio(cpu_prio),
    .user_irq_off(user_irq_off)
  );

  typedef struct {
    logic [15:0] sr;
    logic [3:0]  prio;
    logic        uoff;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t got_e;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // bench model state
  logic m_c = 0, m_z = 0, m_ov = 0, m_n = 0, m_dc = 0, m_ra = 0;
  logic [2:0] m_ipl = '0;

  // driver: apply one cycle of stimulus, predict, push expectation
  task automatic step(input string tag, input logic rn,
                      input logic [15:0] a, input logic [15:0] b, input logic w,
                      input logic [4:0] en, input logic zs,
                      input logic we, input logic [15:0] wd, input logic nd,
                      input logic ih, input logic rs, input logic rc);
    logic [16:0] s17;
    logic [8:0]  s9;
    logic [4:0]  s5;
    logic        f_c, f_z, f_ov, f_n, f_dc, cy;
    logic [15:0] cv;
    exp_t        e;
    s17 = {1'b0, a} + {1'b0, b};
    s9  = {1'b0, a[7:0]} + {1'b0, b[7:0]};
    s5  = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    cy  = 1'b0;
    for (int i = 0; i < 16; i++) begin
      cv[i] = (a[i] & b[i]) | (cy & (a[i] ^ b[i]));
      cy    = cv[i];
    end
    if (w) begin
      f_c = s17[16]; f_dc = s9[8]; f_n = s17[15];
      f_ov = (a[15] == b[15]) && (s17[15] != a[15]);
      f_z = (s17[15:0] == 16'h0);
    end else begin
      f_c = s9[8]; f_dc = s5[4]; f_n = s9[7];
      f_ov = (a[7] == b[7]) && (s9[7] != a[7]);
      f_z = (s9[7:0] == 8'h0);
    end
    if (zs) f_z = f_z ? m_z : 1'b0;

    rst_n = rn; alu_res = s17[15:0]; alu_cout = cv; alu_word = w;
    upd_en = en; z_sticky = zs; sw_we = we; sw_wdata = wd;
    nest_dis = nd; ipl_hi = ih; rpt_set = rs; rpt_clr = rc;

    if (!rn) begin
      {m_c, m_z, m_ov, m_n, m_dc, m_ra} = '0;
      m_ipl = '0;
    end else begin
      m_c  = en[0] ? f_c  : (we ? wd[0] : m_c);
      m_z  = en[1] ? f_z  : (we ? wd[1] : m_z);
      m_ov = en[2] ? f_ov : (we ? wd[2] : m_ov);
      m_n  = en[3] ? f_n  : (we ? wd[3] : m_n);
      m_dc = en[4] ? f_dc : (we ? wd[8] : m_dc);
      if (we && !nd) m_ipl = wd[7:5];
      if (rc) m_ra = 1'b0;
      else if (rs) m_ra = 1'b1;
    end
    e.sr   = {7'b0, m_dc, m_ipl, m_ra, m_n, m_ov, m_z, m_c};
    e.prio = {ih, m_ipl};
    e.uoff = (m_ipl == 3'd7);
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare one cycle after each pushed expectation
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      got_e = q.pop_front();
      checks++;
      if (sr_q !== got_e.sr || cpu_prio !== got_e.prio || user_irq_off !== got_e.uoff) begin
        errors++;
        $display("FAIL %s: got sr=%h prio=%0d off=%b, expected sr=%h prio=%0d off=%b",
                 got_e.tag, sr_q, cpu_prio, user_irq_off, got_e.sr, got_e.prio, got_e.uoff);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    //   tag                    rn  a        b        w  en      zs we wd       nd ih rs rc
    step("R1 reset",            0, 16'h0,   16'h0,   0, 5'h1f, 0, 1, 16'hffff, 0, 0, 1, 0);
    step("R1 reset hold",       0, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 0, 0, 0);
    // R1 R11 R12: write all ones, upper bits and RA stay 0, field 7
    step("R1 write ones",       1, 16'h0,   16'h0,   0, 5'h00, 0, 1, 16'hffff, 0, 1, 0, 0);
    step("R11 locked write",    1, 16'h0,   16'h0,   0, 5'h00, 0, 1, 16'h0000, 1, 1, 0, 0);
    step("R12 ipl write 2",     1, 16'h0,   16'h0,   0, 5'h00, 0, 1, 16'h0040, 0, 0, 0, 0);
    step("R12 ipl_hi joins",    1, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 1, 0, 0);
    // R4 R5 R2: word 7fff+1
    step("R5 word overflow",    1, 16'h7fff,16'h0001,1, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    // R3 R6: word ffff+1
    step("R3 word carry zero",  1, 16'hffff,16'h0001,1, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    // R6 byte: low byte zero, upper nonzero
    step("R6 byte zero",        1, 16'h1280,16'h0080,0, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R2 byte half carry",  1, 16'h000f,16'h0001,0, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R2 word no half",     1, 16'h000f,16'h0001,1, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R2 word half carry",  1, 16'h00f0,16'h0010,1, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R4 byte negative",    1, 16'h0040,16'h0040,0, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R3 byte carry",       1, 16'h00ff,16'h0002,0, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    // R7 sticky zero
    step("R7 set Z normal",     1, 16'h0,   16'h0,   1, 5'h1f, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R7 sticky zero keep", 1, 16'h0,   16'h0,   1, 5'h1f, 1, 0, 16'h0,    0, 0, 0, 0);
    step("R7 sticky nonzero",   1, 16'h0100,16'h0,   1, 5'h1f, 1, 0, 16'h0,    0, 0, 0, 0);
    step("R7 sticky zero stay0",1, 16'h0,   16'h0,   1, 5'h1f, 1, 0, 16'h0,    0, 0, 0, 0);
    // R8 enables: only C, then only N
    step("R8 only C",           1, 16'hffff,16'hffff,1, 5'h01, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R8 only N",           1, 16'h8000,16'h0,   1, 5'h08, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R8 none",             1, 16'h0,   16'h0,   1, 5'h00, 0, 0, 16'h0,    0, 0, 0, 0);
    // R9 hw beats sw
    step("R9 hw C over sw",     1, 16'hffff,16'h0001,1, 5'h01, 0, 1, 16'h0000, 0, 0, 0, 0);
    step("R9 hw Z,DC over sw",  1, 16'h0001,16'h0001,0, 5'h12, 0, 1, 16'h010f, 0, 0, 0, 0);
    // R10 repeat bit
    step("R10 set",             1, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 0, 1, 0);
    step("R10 hold",            1, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 0, 0, 0);
    step("R10 sw write ignored",1, 16'h0,   16'h0,   0, 5'h00, 0, 1, 16'h0000, 0, 0, 0, 0);
    step("R10 clear",           1, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 0, 0, 1);
    step("R10 sw set ignored",  1, 16'h0,   16'h0,   0, 5'h00, 0, 1, 16'h0010, 0, 0, 0, 0);
    step("R10 set",             1, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 0, 1, 0);
    step("R10 clear wins",      1, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 0, 1, 1);
    // R11 R12 priority field
    step("R11 write 5",         1, 16'h0,   16'h0,   0, 5'h00, 0, 1, 16'h00a0, 0, 1, 0, 0);
    step("R11 locked 7",        1, 16'h0,   16'h0,   0, 5'h00, 0, 1, 16'h00e0, 1, 1, 0, 0);
    step("R12 write 7 masked",  1, 16'h0,   16'h0,   0, 5'h00, 0, 1, 16'h00e0, 0, 0, 0, 0);
    step("R12 hi with 7",       1, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 1, 0, 0);
    step("R1 reset again",      0, 16'h0,   16'h0,   0, 5'h00, 0, 0, 16'h0,    0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule